// File: doc/BRIEF.md
# Bit-Manipulation ALU Slice

This block is the bit-manipulation part of an integer execution stage for a 32- or 64-bit core, with the width set by the parameter `XLEN`. It takes two register operands and a 4-bit operation code, and returns one `XLEN`-wide result in the same cycle. Nine operations are supported:

- logic with a complemented second operand: AND-NOT, OR-NOT and XNOR;
- signed and unsigned maximum and minimum;
- left and right rotation.

In the same path it splits the three register indices out of a 32-bit instruction word, so that surrounding decode can steer the register file.

The block has no state. `valid_in` passes straight through to `valid_out`. The unit raises `illegal_op` in two cases:

- the bit-manipulation extension is built in (`HAS_BMANIP`) but the software enable `bmanip_en` is low;
- the operation code is not one of the nine.

While `illegal_op` is high, `valid_out` stays low and the result is forced to zero. Every operation goes through fixed logic with no branch on the operand values, so the timing of the result does not depend on the data.

Top module: `bitmanip_alu`

## Requirements
- R1: With `op_sel` = 0, `result` equals `opnd_a & ~opnd_b`.
- R2: With `op_sel` = 1, `result` equals `opnd_a | ~opnd_b`.
- R3: With `op_sel` = 2, `result` equals `~(opnd_a ^ opnd_b)`.
- R4: With `op_sel` = 3 (signed max) or 5 (signed min), the operands are compared as two's-complement values. The most negative value is the smallest, and the chosen operand is returned at full width.
- R5: With `op_sel` = 4 (unsigned max) or 6 (unsigned min), the operands are compared as unsigned values, and the chosen operand is returned at full width.
- R6: When both min/max operands are equal, all four min/max codes return that common value.
- R7: `op_sel` = 7 rotates `opnd_a` left and `op_sel` = 8 rotates it right. The amount is `opnd_b[$clog2(XLEN)-1:0]`, and all higher bits of `opnd_b` have no effect.
- R8: A rotate amount of 0 returns `opnd_a` unchanged. An amount of XLEN-1 moves every bit to its wrapped position and loses none.
- R9: `rs2_idx` = `insn_word[24:20]`, `rs1_idx` = `insn_word[19:15]` and `rd_idx` = `insn_word[11:7]`, for any operation and enable.
- R10: When `HAS_BMANIP` = 1 and `bmanip_en` = 0, `illegal_op` is 1, `valid_out` is 0 and `result` is 0, for every `op_sel`.
- R11: Codes 9 to 15 on `op_sel` give `illegal_op` = 1, `result` = 0 and `valid_out` = 0.
- R12: For a legal, enabled operation, `illegal_op` is 0 and `valid_out` equals `valid_in` in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| valid_in | input | 1 | Operation request valid |
| op_sel | input | 4 | Operation code (0..8 legal) |
| opnd_a | input | XLEN | First operand |
| opnd_b | input | XLEN | Second operand / rotate amount source |
| insn_word | input | 32 | Instruction word for index extraction |
| bmanip_en | input | 1 | Software enable of the extension |
| valid_out | output | 1 | Result valid |
| illegal_op | output | 1 | Illegal-instruction condition |
| result | output | XLEN | Operation result |
| rs1_idx | output | 5 | First source register index |
| rs2_idx | output | 5 | Second source register index |
| rd_idx | output | 5 | Destination register index |

## Verification
The block holds no state, so an internal fault shows up on `result` or the flags in the same evaluation that applies the faulty inputs. It cannot hide for later cycles. A mis-selected comparison shows as the wrong operand being returned, most visibly when the most negative value is paired with a positive one. A wrong amount slice shows as a rotation that changes when only the upper bits of `opnd_b` change. The bench therefore sweeps every operation code over a grid of corner values and pseudo-random operands, and compares each output against arithmetic computed in the bench.

// File: rtl/bmu_pkg.sv
package bmu_pkg;

    localparam int OP_W   = 4;
    localparam int IDX_W  = 5;
    localparam int INSN_W = 32;

    typedef enum logic [OP_W-1:0] {
        OP_ANDN = 4'd0,
        OP_ORN  = 4'd1,
        OP_XNOR = 4'd2,
        OP_MAX  = 4'd3,
        OP_MAXU = 4'd4,
        OP_MIN  = 4'd5,
        OP_MINU = 4'd6,
        OP_ROL  = 4'd7,
        OP_ROR  = 4'd8
    } bmu_op_e;

    localparam logic [OP_W-1:0] OP_LAST = OP_ROR;

    typedef struct packed {
        logic [IDX_W-1:0] rs2;
        logic [IDX_W-1:0] rs1;
        logic [IDX_W-1:0] rd;
    } reg_spec_t;

    // Register index fields sit at fixed positions of the instruction word.
    function automatic reg_spec_t split_specifiers(input logic [INSN_W-1:0] insn);
        reg_spec_t s;
        s.rs2 = insn[24:20];
        s.rs1 = insn[19:15];
        s.rd  = insn[11:7];
        return s;
    endfunction

    function automatic logic op_known(input logic [OP_W-1:0] code);
        return code <= OP_LAST;
    endfunction

endpackage

// File: rtl/bmu_logic.sv
module bmu_logic #(
    parameter int XLEN = 32
) (
    input  logic [XLEN-1:0] a,
    input  logic [XLEN-1:0] b,
    output logic [XLEN-1:0] andn_o,
    output logic [XLEN-1:0] orn_o,
    output logic [XLEN-1:0] xnor_o
);

    localparam logic [XLEN-1:0] ALL_ONES = '1;

    always_comb begin
        andn_o = a & ~b;
        orn_o  = a | ~b;
        xnor_o = ~(a ^ b);

        AST_ANDN_DISJOINT: assert ((andn_o & b) == '0);          // R1
        AST_ORN_COVERS:    assert ((~b & ~orn_o) == '0);         // R2
        AST_XNOR_PARITY:   assert ((xnor_o ^ a ^ b) == ALL_ONES); // R3
    end

endmodule

// File: rtl/bmu_minmax.sv
module bmu_minmax #(
    parameter int XLEN = 32
) (
    input  logic [XLEN-1:0] a,
    input  logic [XLEN-1:0] b,
    output logic [XLEN-1:0] smax_o,
    output logic [XLEN-1:0] smin_o,
    output logic [XLEN-1:0] umax_o,
    output logic [XLEN-1:0] umin_o
);

    logic a_lt_b_s;
    logic a_lt_b_u;

    always_comb begin
        a_lt_b_s = $signed(a) < $signed(b);
        a_lt_b_u = a < b;
        smax_o   = a_lt_b_s ? b : a;
        smin_o   = a_lt_b_s ? a : b;
        umax_o   = a_lt_b_u ? b : a;
        umin_o   = a_lt_b_u ? a : b;

        AST_SIGNED_ORDER:   assert ($signed(smax_o) >= $signed(smin_o)); // R4
        AST_UNSIGNED_ORDER: assert (umax_o >= umin_o);                   // R5
        AST_PICKS_OPERAND:  assert ((smax_o == a || smax_o == b) &&
                                    (umin_o == a || umin_o == b));       // R6
    end

endmodule

// File: rtl/bmu_rotate.sv
module bmu_rotate #(
    parameter int XLEN = 32,
    localparam int SH_W = $clog2(XLEN)
) (
    input  logic [XLEN-1:0] a,
    input  logic [SH_W-1:0] amt,
    output logic [XLEN-1:0] rol_o,
    output logic [XLEN-1:0] ror_o
);

    logic [2*XLEN-1:0] dbl;
    logic [2*XLEN-1:0] dbl_l;
    logic [2*XLEN-1:0] dbl_r;

    always_comb begin
        dbl   = {a, a};
        dbl_l = dbl << amt;
        dbl_r = dbl >> amt;
        rol_o = dbl_l[2*XLEN-1:XLEN];
        ror_o = dbl_r[XLEN-1:0];

        AST_ROT_KEEPS_BITS: assert ($countones(rol_o) == $countones(a) &&
                                    $countones(ror_o) == $countones(a)); // R7
        AST_ROT_ZERO:       assert (amt != '0 || (rol_o == a && ror_o == a)); // R8
    end

endmodule

// File: rtl/bitmanip_alu.sv
module bitmanip_alu
    import bmu_pkg::*;
#(
    parameter int XLEN       = 32,
    parameter bit HAS_BMANIP = 1'b1
) (
    input  logic                valid_in,
    input  logic [OP_W-1:0]     op_sel,
    input  logic [XLEN-1:0]     opnd_a,
    input  logic [XLEN-1:0]     opnd_b,
    input  logic [INSN_W-1:0]   insn_word,
    input  logic                bmanip_en,
    output logic                valid_out,
    output logic                illegal_op,
    output logic [XLEN-1:0]     result,
    output logic [IDX_W-1:0]    rs1_idx,
    output logic [IDX_W-1:0]    rs2_idx,
    output logic [IDX_W-1:0]    rd_idx
);

    localparam int SH_W = $clog2(XLEN);

    logic [XLEN-1:0] andn_v, orn_v, xnor_v;
    logic [XLEN-1:0] smax_v, smin_v, umax_v, umin_v;
    logic [XLEN-1:0] rol_v, ror_v;
    logic            gate_off;
    logic [XLEN-1:0] raw_res;
    reg_spec_t       spec;

    bmu_logic #(.XLEN(XLEN)) u_logic (
        .a(opnd_a), .b(opnd_b),
        .andn_o(andn_v), .orn_o(orn_v), .xnor_o(xnor_v)
    );

    bmu_minmax #(.XLEN(XLEN)) u_minmax (
        .a(opnd_a), .b(opnd_b),
        .smax_o(smax_v), .smin_o(smin_v), .umax_o(umax_v), .umin_o(umin_v)
    );

    bmu_rotate #(.XLEN(XLEN)) u_rotate (
        .a(opnd_a), .amt(opnd_b[SH_W-1:0]),
        .rol_o(rol_v), .ror_o(ror_v)
    );

    generate
        if (HAS_BMANIP) begin : g_gated
            assign gate_off = ~bmanip_en;
        end else begin : g_open
            assign gate_off = 1'b0;
        end
    endgenerate

    always_comb begin
        unique case (op_sel)
            OP_ANDN: raw_res = andn_v;
            OP_ORN:  raw_res = orn_v;
            OP_XNOR: raw_res = xnor_v;
            OP_MAX:  raw_res = smax_v;
            OP_MAXU: raw_res = umax_v;
            OP_MIN:  raw_res = smin_v;
            OP_MINU: raw_res = umin_v;
            OP_ROL:  raw_res = rol_v;
            OP_ROR:  raw_res = ror_v;
            default: raw_res = '0;
        endcase
    end

    always_comb begin
        illegal_op = gate_off | ~op_known(op_sel);
        valid_out  = valid_in & ~illegal_op;
        result     = illegal_op ? '0 : raw_res;

        AST_ILLEGAL_SILENT: assert (!illegal_op || (!valid_out && result == '0)); // R10
        AST_UNKNOWN_FLAGS:  assert (op_known(op_sel) || illegal_op);             // R11
    end

    always_comb begin
        spec    = split_specifiers(insn_word);
        rs1_idx = spec.rs1;
        rs2_idx = spec.rs2;
        rd_idx  = spec.rd;
    end

endmodule

// File: tb/bitmanip_alu_bench.sv
module bitmanip_alu_bench;

    localparam int XLEN = 32;
    localparam int SH_W = $clog2(XLEN);
    localparam logic [XLEN-1:0] MSB = {1'b1, {(XLEN-1){1'b0}}};

    logic            clk = 1'b0;
    logic            rst = 1'b1;
    logic            valid_in;
    logic [3:0]      op_sel;
    logic [XLEN-1:0] opnd_a, opnd_b;
    logic [31:0]     insn_word;
    logic            bmanip_en;
    logic            valid_out, illegal_op;
    logic [XLEN-1:0] result;
    logic [4:0]      rs1_idx, rs2_idx, rd_idx;

    int checks = 0;
    int failures = 0;
    bit finished = 1'b0;
    logic [31:0] lfsr = 32'hACE1_2468;

    always #10 clk = ~clk; // 50 MHz

    bitmanip_alu #(.XLEN(XLEN), .HAS_BMANIP(1'b1)) u_bitmanip_alu (
        .valid_in(valid_in), .op_sel(op_sel), .opnd_a(opnd_a), .opnd_b(opnd_b),
        .insn_word(insn_word), .bmanip_en(bmanip_en),
        .valid_out(valid_out), .illegal_op(illegal_op), .result(result),
        .rs1_idx(rs1_idx), .rs2_idx(rs2_idx), .rd_idx(rd_idx)
    );

    function automatic logic [31:0] next_rand(input logic [31:0] s);
        return {s[30:0], s[31] ^ s[21] ^ s[1] ^ s[0]};
    endfunction

    function automatic logic [XLEN-1:0] rot_model(input logic [XLEN-1:0] a,
                                                  input int amt, input bit left);
        logic [XLEN-1:0] r;
        for (int i = 0; i < XLEN; i++) begin
            if (left) r[(i + amt) % XLEN] = a[i];
            else      r[i] = a[(i + amt) % XLEN];
        end
        return r;
    endfunction

    function automatic logic [XLEN-1:0] model(input logic [3:0] op,
                                              input logic [XLEN-1:0] a,
                                              input logic [XLEN-1:0] b);
        logic s_gt, u_gt;
        int amt;
        s_gt = (a ^ MSB) > (b ^ MSB);
        u_gt = a > b;
        amt  = int'(b % XLEN);
        case (op)
            4'd0: return a & ~b;
            4'd1: return a | ~b;
            4'd2: return ~(a ^ b);
            4'd3: return s_gt ? a : b;
            4'd4: return u_gt ? a : b;
            4'd5: return s_gt ? b : a;
            4'd6: return u_gt ? b : a;
            4'd7: return rot_model(a, amt, 1'b1);
            4'd8: return rot_model(a, amt, 1'b0);
            default: return '0;
        endcase
    endfunction

    function automatic string req_of(input logic [3:0] op);
        case (op)
            4'd0: return "R1";
            4'd1: return "R2";
            4'd2: return "R3";
            4'd3, 4'd5: return "R4";
            4'd4, 4'd6: return "R5";
            4'd7, 4'd8: return "R7";
            default: return "R11";
        endcase
    endfunction

    task automatic check(input string req, input string what,
                         input logic [XLEN-1:0] act, input logic [XLEN-1:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    task automatic apply(input logic vin, input logic [3:0] op,
                         input logic [XLEN-1:0] a, input logic [XLEN-1:0] b,
                         input logic en);
        @(negedge clk);
        valid_in = vin; op_sel = op; opnd_a = a; opnd_b = b; bmanip_en = en;
        #2;
    endtask

    task automatic run_vec(input logic [3:0] op, input logic [XLEN-1:0] a,
                           input logic [XLEN-1:0] b, input string req);
        logic legal;
        legal = (op <= 4'd8);
        apply(1'b1, op, a, b, 1'b1);
        check(req, "result", result, model(op, a, b));
        check(legal ? "R12" : "R11", "illegal_op", {{(XLEN-1){1'b0}}, illegal_op},
              {{(XLEN-1){1'b0}}, ~legal});
        check(legal ? "R12" : "R11", "valid_out", {{(XLEN-1){1'b0}}, valid_out},
              {{(XLEN-1){1'b0}}, legal});
    endtask

    logic [XLEN-1:0] corners [12];

    initial begin
        corners[0]  = '0;
        corners[1]  = 1;
        corners[2]  = '1;
        corners[3]  = MSB;
        corners[4]  = ~MSB;
        corners[5]  = MSB | 1;
        corners[6]  = 32'h5555_5555;
        corners[7]  = 32'hAAAA_AAAA;
        corners[8]  = 32'h0000_001F;
        corners[9]  = 32'hFFFF_FFE0;
        corners[10] = 32'h1234_5678;
        corners[11] = 32'h8000_0020;

        valid_in = 1'b0; op_sel = '0; opnd_a = '0; opnd_b = '0;
        insn_word = '0; bmanip_en = 1'b1;
        repeat (3) @(posedge clk);
        rst = 1'b0;

        // Idle state: no request, no output valid
        @(negedge clk); #2;
        check("R12", "idle valid_out", {{(XLEN-1){1'b0}}, valid_out}, '0);
        check("R12", "idle illegal_op", {{(XLEN-1){1'b0}}, illegal_op}, '0);

        // Corner grid over every code, including unknown ones (R11)
        for (int op = 0; op < 16; op++)
            for (int i = 0; i < 12; i++)
                for (int j = 0; j < 12; j++)
                    run_vec(4'(op), corners[i], corners[j], req_of(4'(op)));

        // Pseudo-random operands
        for (int n = 0; n < 400; n++) begin
            logic [XLEN-1:0] ra, rb;
            lfsr = next_rand(lfsr); ra = lfsr;
            lfsr = next_rand(lfsr); rb = lfsr;
            for (int op = 0; op < 9; op++) run_vec(4'(op), ra, rb, req_of(4'(op)));
        end

        // R6: equal operands on all min/max codes
        for (int i = 0; i < 12; i++)
            for (int op = 3; op <= 6; op++) begin
                apply(1'b1, 4'(op), corners[i], corners[i], 1'b1);
                check("R6", "equal minmax", result, corners[i]);
            end

        // R4: most negative value against most positive
        apply(1'b1, 4'd5, ~MSB, MSB, 1'b1);
        check("R4", "smin mostneg", result, MSB);
        apply(1'b1, 4'd3, MSB, ~MSB, 1'b1);
        check("R4", "smax mostpos", result, ~MSB);

        // R7/R8: full amount sweep with upper bits of the amount source varied
        for (int amt = 0; amt < XLEN; amt++) begin
            logic [XLEN-1:0] hi;
            lfsr = next_rand(lfsr);
            hi = lfsr & ~XLEN'((1 << SH_W) - 1);
            apply(1'b1, 4'd7, 32'h8000_0003, hi | XLEN'(amt), 1'b1);
            check(amt == 0 ? "R8" : "R7", "rol sweep", result,
                  rot_model(32'h8000_0003, amt, 1'b1));
            apply(1'b1, 4'd8, 32'h8000_0003, hi | XLEN'(amt), 1'b1);
            check(amt == 0 ? "R8" : "R7", "ror sweep", result,
                  rot_model(32'h8000_0003, amt, 1'b0));
        end
        apply(1'b1, 4'd7, 32'hC000_0001, XLEN'(XLEN - 1), 1'b1);
        check("R8", "rol by XLEN-1", result, 32'hE000_0000);
        apply(1'b1, 4'd8, 32'hC000_0001, XLEN'(XLEN - 1), 1'b1);
        check("R8", "ror by XLEN-1", result, 32'h8000_0003);

        // R10: enable cleared blocks every code
        for (int op = 0; op < 16; op++) begin
            apply(1'b1, 4'(op), 32'h1357_9BDF, 32'h0000_0004, 1'b0);
            check("R10", "gated result", result, '0);
            check("R10", "gated illegal", {{(XLEN-1){1'b0}}, illegal_op}, 1);
            check("R10", "gated valid", {{(XLEN-1){1'b0}}, valid_out}, '0);
        end

        // R12: valid passthrough low
        apply(1'b0, 4'd1, 32'h1, 32'h2, 1'b1);
        check("R12", "valid low passthrough", {{(XLEN-1){1'b0}}, valid_out}, '0);

        // R9: register index extraction under any op and enable
        for (int n = 0; n < 200; n++) begin
            logic [31:0] w;
            lfsr = next_rand(lfsr); w = lfsr;
            @(negedge clk);
            insn_word = w; bmanip_en = w[0]; op_sel = w[3:0];
            #2;
            check("R9", "rs2_idx", XLEN'(rs2_idx), XLEN'(w[24:20]));
            check("R9", "rs1_idx", XLEN'(rs1_idx), XLEN'(w[19:15]));
            check("R9", "rd_idx",  XLEN'(rd_idx),  XLEN'(w[11:7]));
        end

        finished = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            checks++;
            failures++;
            $display("FAIL watchdog expired actual=running expected=done");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

endmodule